// File: doc/BRIEF.md
# Link Controller Interrupt Cause and Mask Register

This block holds the interrupt cause register and its companion mask register for a serial-link controller. Event logic elsewhere in the controller raises single-cycle pulses, one per cause position. Each pulse sets a sticky cause bit, and the bit stays at 1 until software clears it by writing 0 to that position. Four positions are not sticky. They report the level of the four legacy interrupt lines (A to D), and only assert and deassert emulation messages from the link change them. Software writes cannot touch them.

Software reaches both registers through one simple port. A select bit picks the cause register or the mask register, and the same select drives the combinational read-back. A registered interrupt output goes high while any cause bit is set and its mask bit is 1. Each legacy line is tracked by a small two-state machine. LEG_IDLE moves to LEG_ACTIVE on an assert strobe that has no deassert strobe in the same cycle. LEG_ACTIVE returns to LEG_IDLE on any deassert strobe. Every other input leaves the state unchanged.

Top module: `irq_cause_mask`

## Requirements
- R1: After reset the cause register, the mask register and `irq_out` are all 0.
- R2: A 1 on `evt_pulse[i]` sets cause bit i, and the bit stays at 1 until software clears it. This applies to the sticky positions 0, 1, 3, 4, 6–12, 14–23 and 28.
- R3: A write to the cause register (`reg_sel`=0) clears each sticky bit whose data bit is 0. Sticky bits whose data bit is 1 keep their value.
- R4: If an event pulse and a clearing write hit the same sticky bit in the same cycle, the bit ends at 1.
- R5: Cause bits 24, 25, 26 and 27 show the state of legacy lines A, B, C and D. `leg_assert[k]` sets bit 24+k and `leg_deassert[k]` clears it, with effect on the next clock edge.
- R6: Software writes to the cause register and event pulses on positions 27:24 have no effect on bits 27:24.
- R7: If `leg_assert[k]` and `leg_deassert[k]` arrive in the same cycle, bit 24+k ends at 0.
- R8: Positions 2, 5, 13, 29, 30 and 31 read as 0 in both registers. Writes and event pulses to these positions are ignored.
- R9: A write with `reg_sel`=1 loads the mask, and the mask reads back through `rd_data`. The mask does not affect whether a cause bit gets set.
- R10: `irq_out` is a registered OR over (cause AND mask). It changes one clock after the cause or mask change that causes it.
- R11: Reading either register leaves every bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the cause register, 1 selects the mask register (for both write and read) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the selected register |
| evt_pulse | input | 32 | Single-cycle event pulses, one per cause position |
| leg_assert | input | 4 | Legacy line assert message strobes, lines A to D |
| leg_deassert | input | 4 | Legacy line deassert message strobes, lines A to D |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench goes after several corner cases, each of which exposes a specific design error:
- Event pulse and clearing write in the same cycle: a design that lets the write win loses an event.
- Clear polarity: a design with write-one-to-clear semantics wipes bits that software meant to keep.
- Legacy bits against writes and stray event pulses: a design without this protection lets software drop a level-sensitive line.
- Assert and deassert on the same line together: a design that gives assert priority leaves a line stuck high.
- Reserved positions and interrupt timing: the bench checks that reserved positions read as 0, and that `irq_out` rises exactly one clock after the mask or cause change. An unregistered output, or a mask that gates setting, shows up as the wrong value in that cycle.

// File: rtl/irq_cm_pkg.sv
package irq_cm_pkg;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned LEG_N   = 4;
    localparam int unsigned LEG_LSB = 24;

    // Positions software decodes; fixed by the register layout.
    localparam logic [REG_W-1:0] STICKY_BITS = 32'h10FF_DFDB;
    localparam logic [REG_W-1:0] LEG_BITS    = 32'h0F00_0000;
    localparam logic [REG_W-1:0] LIVE_BITS   = STICKY_BITS | LEG_BITS;

    typedef enum logic {
        LEG_IDLE   = 1'b0,
        LEG_ACTIVE = 1'b1
    } leg_state_e;

    typedef enum logic {
        SEL_CAUSE = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         clr_en,
    input  logic [W-1:0] clr_data,
    output logic [W-1:0] bits_q
);

    logic [W-1:0] hold_mask;
    logic [W-1:0] bits_d;

    always_comb begin
        hold_mask = clr_en ? clr_data : '1;
        // Event OR-ed in last: an event beats a same-cycle clear.
        bits_d    = ((bits_q & hold_mask) | evt) & KEEP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

endmodule

// File: rtl/irq_leg_line.sv
module irq_leg_line
    import irq_cm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_msg,
    input  logic clr_msg,
    output logic active
);

    leg_state_e state_q;
    leg_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LEG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LEG_IDLE: begin
                if (set_msg && !clr_msg) begin
                    state_d = LEG_ACTIVE;
                end
            end
            LEG_ACTIVE: begin
                if (clr_msg) begin
                    state_d = LEG_IDLE;
                end
            end
            default: state_d = LEG_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q == LEG_ACTIVE);
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] bits_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q <= wr_data & KEEP;
        end
    end

endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cause,
    input  logic [W-1:0] enable,
    output logic         irq_q
);

    logic hit;

    always_comb begin
        hit = |(cause & enable);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit;
        end
    end

endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
    import irq_cm_pkg::*;
#(
    parameter int unsigned W      = REG_W,
    parameter int unsigned NLEG   = LEG_N,
    parameter int unsigned LEG_LO = LEG_LSB
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         reg_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] evt_pulse,
    input  logic [NLEG-1:0] leg_assert,
    input  logic [NLEG-1:0] leg_deassert,
    output logic         irq_out
);

    localparam int unsigned TOP_PAD = W - LEG_LO - NLEG;

    logic            wr_cause;
    logic            wr_mask;
    logic [W-1:0]    sticky_q;
    logic [W-1:0]    mask_q;
    logic [W-1:0]    cause_q;
    logic [NLEG-1:0] leg_vec;

    always_comb begin
        wr_cause = wr_en && (reg_sel == SEL_CAUSE);
        wr_mask  = wr_en && (reg_sel == SEL_MASK);
    end

    irq_sticky_bank #(
        .W    (W),
        .KEEP (STICKY_BITS)
    ) u_sticky (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt_pulse),
        .clr_en   (wr_cause),
        .clr_data (wr_data),
        .bits_q   (sticky_q)
    );

    for (genvar k = 0; k < NLEG; k++) begin : g_leg
        irq_leg_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_msg (leg_assert[k]),
            .clr_msg (leg_deassert[k]),
            .active  (leg_vec[k])
        );
    end

    irq_mask_reg #(
        .W    (W),
        .KEEP (LIVE_BITS)
    ) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_mask),
        .wr_data (wr_data),
        .bits_q  (mask_q)
    );

    always_comb begin
        cause_q = sticky_q | {{TOP_PAD{1'b0}}, leg_vec, {LEG_LO{1'b0}}};
    end

    irq_out_gen #(
        .W (W)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cause  (cause_q),
        .enable (mask_q),
        .irq_q  (irq_out)
    );

    always_comb begin
        rd_data = (reg_sel == SEL_MASK) ? mask_q : cause_q;
    end

endmodule

// File: rtl/irq_cause_mask_chk.sv
module irq_cause_mask_chk
    import irq_cm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             reg_sel,
    input logic [REG_W-1:0] evt_pulse,
    input logic [LEG_N-1:0] leg_assert,
    input logic [LEG_N-1:0] leg_deassert,
    input logic [REG_W-1:0] cause,
    input logic [REG_W-1:0] mask,
    input logic             irq_out
);

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_pulse & STICKY_BITS) != '0) |=>
        ((cause & $past(evt_pulse & STICKY_BITS)) == $past(evt_pulse & STICKY_BITS)));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause & ~$past(cause) & STICKY_BITS & ~$past(evt_pulse)) == '0));

    // R6
    leg_sw_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_assert == '0 && leg_deassert == '0) |=> $stable(cause[27:24]));

    // R7
    leg_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((leg_assert & leg_deassert) != '0) |=>
        ((cause[27:24] & $past(leg_assert & leg_deassert)) == '0));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & ~LIVE_BITS) == '0) && ((mask & ~LIVE_BITS) == '0));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == ($past(cause & mask) != '0)));

    // R9
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_sel) |=> $stable(mask));

endmodule

bind irq_cause_mask irq_cause_mask_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .reg_sel      (reg_sel),
    .evt_pulse    (evt_pulse),
    .leg_assert   (leg_assert),
    .leg_deassert (leg_deassert),
    .cause        (cause_q),
    .mask         (mask_q),
    .irq_out      (irq_out)
);

// File: tb/irq_cause_mask_tb.sv
module irq_cause_mask_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        reg_sel;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [31:0] evt_pulse;
    logic [3:0]  leg_assert;
    logic [3:0]  leg_deassert;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_cause_mask u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .reg_sel      (reg_sel),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .evt_pulse    (evt_pulse),
        .leg_assert   (leg_assert),
        .leg_deassert (leg_deassert),
        .irq_out      (irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        reg_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; reg_sel = 1'b0;
    endtask

    task automatic ev(input logic [31:0] e);
        @(negedge clk);
        evt_pulse = e;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    task automatic msg(input logic [3:0] a, input logic [3:0] d);
        @(negedge clk);
        leg_assert = a; leg_deassert = d;
        @(negedge clk);
        leg_assert = '0; leg_deassert = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(1'b0, v); check("R1 cause", v, 32'h0);
        rd(1'b1, v); check("R1 mask", v, 32'h0);
        check("R1 irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_event_set();
        logic [31:0] v;
        ev(32'h0000_0003);
        repeat (3) @(negedge clk);
        rd(1'b0, v); check("R2 sticky hold", v, 32'h0000_0003);
        ev(32'hFFFF_FFFF);
        rd(1'b0, v); check("R2 R8 all events", v, 32'h10FF_DFDB);
    endtask

    task automatic t_sw_clear();
        logic [31:0] v;
        wr(1'b0, 32'hFFFF_FFFE);
        rd(1'b0, v); check("R3 clear bit0", v, 32'h10FF_DFDA);
        wr(1'b0, 32'hFFFF_FFFF);
        rd(1'b0, v); check("R3 ones keep", v, 32'h10FF_DFDA);
        wr(1'b0, 32'h0);
        rd(1'b0, v); check("R3 clear all", v, 32'h0);
    endtask

    task automatic t_race();
        logic [31:0] v;
        ev(32'h0000_0100);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = 1'b0; wr_data = 32'h0; evt_pulse = 32'h0000_0300;
        @(negedge clk);
        wr_en = 1'b0; evt_pulse = '0;
        rd(1'b0, v); check("R4 event wins", v, 32'h0000_0300);
        wr(1'b0, 32'h0);
    endtask

    task automatic t_legacy();
        logic [31:0] v;
        msg(4'b0010, 4'b0000);
        rd(1'b0, v); check("R5 INTB set", v, 32'h0200_0000);
        msg(4'b1000, 4'b0000);
        rd(1'b0, v); check("R5 INTD set", v, 32'h0A00_0000);
        msg(4'b0000, 4'b0010);
        rd(1'b0, v); check("R5 INTB clear", v, 32'h0800_0000);
    endtask

    task automatic t_leg_sw();
        logic [31:0] v;
        wr(1'b0, 32'h0);
        rd(1'b0, v); check("R6 write ignored", v, 32'h0800_0000);
        ev(32'h0400_0000);
        rd(1'b0, v); check("R6 event ignored", v, 32'h0800_0000);
    endtask

    task automatic t_leg_tie();
        logic [31:0] v;
        msg(4'b0001, 4'b0001);
        rd(1'b0, v); check("R7 tie from idle", v, 32'h0800_0000);
        msg(4'b0001, 4'b0000);
        rd(1'b0, v); check("R7 INTA set", v, 32'h0900_0000);
        msg(4'b0001, 4'b0001);
        rd(1'b0, v); check("R7 tie from active", v, 32'h0800_0000);
        msg(4'b0000, 4'b1000);
        rd(1'b0, v); check("R5 INTD clear", v, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] v;
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, v); check("R8 R9 mask live bits", v, 32'h1FFF_DFDB);
        ev(32'hE000_2024);
        rd(1'b0, v); check("R8 reserved events", v, 32'h0);
        wr(1'b1, 32'h0);
    endtask

    task automatic t_mask_irq();
        logic [31:0] v;
        ev(32'h0000_0400);
        rd(1'b0, v); check("R9 set while masked", v, 32'h0000_0400);
        check("R10 masked irq", {31'b0, irq_out}, 32'h0);
        wr(1'b1, 32'h0000_0400);
        check("R10 irq one cycle later", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R10 irq high", {31'b0, irq_out}, 32'h1);
        wr(1'b0, 32'h0);
        check("R10 irq lags clear", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R10 irq low", {31'b0, irq_out}, 32'h0);
        wr(1'b1, 32'h0200_0000);
        msg(4'b0010, 4'b0000);
        @(negedge clk);
        check("R10 legacy irq", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_read();
        logic [31:0] v;
        ev(32'h0000_8001);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            rd(1'b0, v);
            rd(1'b1, v);
        end
        @(negedge clk);
        rd(1'b0, v); check("R11 cause after reads", v, 32'h0200_8001);
        rd(1'b1, v); check("R11 mask after reads", v, 32'h0200_0000);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; reg_sel = 1'b0; wr_data = '0;
        evt_pulse = '0; leg_assert = '0; leg_deassert = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event_set();
        t_sw_clear();
        t_race();
        t_legacy();
        t_leg_sw();
        t_leg_tie();
        t_reserved();
        t_mask_irq();
        t_read();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule